// File: doc/BRIEF.md
# Transmit End-to-End CRC Insertion Stage

This stage sits in the outgoing transaction-layer packet path, between the application and the link layer. Packets move through it as a stream of 32-bit dwords with valid/ready flow control and start/end markers. For each packet it looks at two static configuration inputs (a forwarding mode and a generation enable) and at the digest (TD) bit in the first header dword. It then does one of three things. It clears the digest bit. It sets the digest bit and appends a freshly computed CRC-32 as an extra trailing dword. Or it passes the packet through untouched, together with any digest the application already attached.

The policy is chosen on the start beat of each packet and held until that packet's last beat has gone out. A configuration change in the middle of a packet therefore never produces a half-rewritten packet. A packet that starts and ends on the same beat cannot hold a header. It is treated as an unsupported case: it is passed through unmodified and flagged with a one-cycle error pulse.

Top module: `ecrc_tx_stage`

## Requirements
- R1: With forwarding off and generation off, every packet leaves with bit 15 (TD) of its first dword cleared. No extra beat is added, and all other bits and beats are unchanged.
- R2: With forwarding off and generation on, every packet leaves with bit 15 of its first dword set. One extra beat follows the original last beat, and the end marker moves to that extra beat. This holds whatever TD value the application set.
- R3: With forwarding on, every packet passes bit-for-bit unchanged, including its end position, for either generation setting and either TD value.
- R4: The appended dword is a CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF, and the final remainder is inverted. Each dword is fed most-significant bit first, over all dwords of the packet. In the first dword, bits 15 (TD) and 14 (EP) are taken as 1 for the calculation.
- R5: While the appended dword is being presented, in_ready is low. A beat held on the output under backpressure stays stable, and no input beat is lost or duplicated.
- R6: A packet that starts and ends on the same beat is passed through unmodified, whatever the configuration. err_unsup is high for exactly the one cycle after that beat is accepted, and low at all other times.
- R7: The policy is taken from the configuration inputs on the start beat. Changing them on later beats of the same packet has no effect on that packet.
- R8: During and right after reset, out_valid and err_unsup are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fwd_en | input | 1 | Forwarding mode: pass packets and their digests unchanged |
| cfg_gen_en | input | 1 | Generation enable, used when forwarding is off |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Stage accepts the input beat |
| in_sop | input | 1 | Input beat is the first of a packet |
| in_eop | input | 1 | Input beat is the last of a packet |
| in_data | input | 32 | Input dword |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_sop | output | 1 | Output beat is the first of a packet |
| out_eop | output | 1 | Output beat is the last of a packet |
| out_data | output | 32 | Output dword |
| err_unsup | output | 1 | One-cycle pulse after an unsupported packet is accepted |

## Verification
The bench sweeps every configuration pair against both TD values and several packet lengths, including a one-beat packet. It repeats the sweep under three downstream stall patterns. It goes after a CRC seeded from the previous packet or computed over the raw TD/EP bits, which would show as a wrong trailing dword. It also checks that in_ready drops during the appended beat; if it did not, the next packet's first dword would be swallowed and the output stream would shift. Packets whose configuration inputs toggle after the start beat expose a design that reads the live inputs, because such a design would drop or add the trailing beat. The sweep also catches a missing or stretched error pulse on the one-beat packets.

// File: rtl/ecrc_tx_pkg.sv
package ecrc_tx_pkg;

  localparam int DW = 32;
  localparam logic [DW-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [DW-1:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam int TD_BIT = 15;
  localparam int EP_BIT = 14;
  localparam logic [DW-1:0] HDR_FORCE = (DW'(1) << TD_BIT) | (DW'(1) << EP_BIT);

  typedef enum logic [1:0] {
    POL_CLEAR = 2'd0,
    POL_GEN   = 2'd1,
    POL_PASS  = 2'd2,
    POL_UNSUP = 2'd3
  } ecrc_pol_e;

  // One dword into the CRC register, most significant bit first.
  function automatic logic [DW-1:0] crc_step(input logic [DW-1:0] crc,
                                             input logic [DW-1:0] d);
    logic [DW-1:0] c;
    c = crc;
    for (int i = DW - 1; i >= 0; i--) begin
      if (c[DW-1] ^ d[i]) c = (c << 1) ^ CRC_POLY;
      else                c = c << 1;
    end
    return c;
  endfunction

  function automatic ecrc_pol_e pick_policy(input logic fwd, input logic gen,
                                            input logic single_beat);
    if (single_beat) return POL_UNSUP;
    if (fwd)         return POL_PASS;
    if (gen)         return POL_GEN;
    return POL_CLEAR;
  endfunction

  function automatic logic [DW-1:0] rewrite_hdr(input logic [DW-1:0] d,
                                                input ecrc_pol_e pol);
    logic [DW-1:0] r;
    r = d;
    if (pol == POL_CLEAR) r[TD_BIT] = 1'b0;
    if (pol == POL_GEN)   r[TD_BIT] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/ecrc_tx_policy.sv
module ecrc_tx_policy
  import ecrc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_fwd_en,
  input  logic      cfg_gen_en,
  input  logic      sop_present,
  input  logic      eop_present,
  input  logic      beat_accept,
  output ecrc_pol_e pol_now
);

  ecrc_pol_e pol_q;
  ecrc_pol_e pol_live;
  logic      active_q;
  logic      sop_accept;

  assign pol_live   = pick_policy(cfg_fwd_en, cfg_gen_en, eop_present);
  assign sop_accept = beat_accept && sop_present;
  assign pol_now    = sop_present ? pol_live : pol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pol_q    <= POL_PASS;
      active_q <= 1'b0;
    end else begin
      if (sop_accept) pol_q <= pol_live;
      if (beat_accept) active_q <= !eop_present;
    end
  end

  AST_POLICY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !sop_accept) |=> $stable(pol_q)); // R7

endmodule

// File: rtl/ecrc_tx_crc.sv
module ecrc_tx_crc
  import ecrc_tx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_accept,
  input  logic          first_beat,
  input  logic [DW-1:0] beat_data,
  output logic [DW-1:0] crc_word
);

  logic [DW-1:0] crc_q;
  logic [DW-1:0] crc_base;
  logic [DW-1:0] crc_feed;

  assign crc_base = first_beat ? CRC_SEED : crc_q;
  assign crc_feed = first_beat ? (beat_data | HDR_FORCE) : beat_data;
  assign crc_word = ~crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           crc_q <= CRC_SEED;
    else if (beat_accept) crc_q <= crc_step(crc_base, crc_feed);
  end

endmodule

// File: rtl/ecrc_tx_stage.sv
module ecrc_tx_stage
  import ecrc_tx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_fwd_en,
  input  logic          cfg_gen_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sop,
  input  logic          in_eop,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_sop,
  output logic          out_eop,
  output logic [DW-1:0] out_data,
  output logic          err_unsup
);

  ecrc_pol_e     pol_now;
  logic          append_q;
  logic          err_q;
  logic          beat_acc;
  logic          gen_eop_acc;
  logic [DW-1:0] crc_word;

  assign in_ready    = out_ready && !append_q;
  assign beat_acc    = in_valid && in_ready;
  assign gen_eop_acc = beat_acc && in_eop && (pol_now == POL_GEN);

  ecrc_tx_policy u_policy (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fwd_en  (cfg_fwd_en),
    .cfg_gen_en  (cfg_gen_en),
    .sop_present (in_valid && in_sop),
    .eop_present (in_eop),
    .beat_accept (beat_acc),
    .pol_now     (pol_now)
  );

  ecrc_tx_crc u_crc (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat_accept (beat_acc),
    .first_beat  (in_sop),
    .beat_data   (in_data),
    .crc_word    (crc_word)
  );

  assign out_valid = append_q || in_valid;
  assign out_sop   = append_q ? 1'b0 : in_sop;
  assign out_eop   = append_q ? 1'b1 : (in_eop && (pol_now != POL_GEN));
  assign out_data  = append_q ? crc_word
                   : (in_sop ? rewrite_hdr(in_data, pol_now) : in_data);
  assign err_unsup = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      append_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (append_q && out_ready) append_q <= 1'b0;
      else if (gen_eop_acc)      append_q <= 1'b1;
      err_q <= beat_acc && in_sop && in_eop;
    end
  end

  AST_APPEND_BLOCKS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    gen_eop_acc |=> (out_valid && out_eop && !out_sop && !in_ready)); // R2

  AST_CLEAR_TD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && pol_now == POL_CLEAR) |-> !out_data[TD_BIT]); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (append_q && !out_ready) |=> (out_valid && $stable(out_data))); // R5

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_unsup |-> $past(out_valid && out_ready && out_sop && out_eop)); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(!rst_n) |-> !err_unsup); // R8

endmodule

// File: tb/ecrc_tx_stage_bench.sv
module ecrc_tx_stage_bench;

  localparam int MAXB = 4096;
  localparam logic [31:0] POLY = 32'h04C1_1DB7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_fwd_en = 1'b0, cfg_gen_en = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic out_ready = 1'b1;
  logic in_ready, out_valid, out_sop, out_eop, err_unsup;
  logic [31:0] out_data;

  always #4 clk = ~clk;

  ecrc_tx_stage u_ecrc_tx_stage (
    .clk(clk), .rst_n(rst_n), .cfg_fwd_en(cfg_fwd_en), .cfg_gen_en(cfg_gen_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data), .err_unsup(err_unsup)
  );

  int checks = 0, errors = 0;
  logic [31:0] b_data [MAXB];
  logic        b_sop [MAXB], b_eop [MAXB], b_fwd [MAXB], b_gen [MAXB];
  int nb = 0;
  logic [31:0] e_data [MAXB];
  logic        e_sop [MAXB], e_eop [MAXB], e_app [MAXB];
  string       e_tag [MAXB];
  int ne = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [31:0] w [16], input int len);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int j = 0; j < len; j++) begin
      logic [31:0] x = (j == 0) ? (w[0] | 32'h0000_C000) : w[j];
      for (int b = 31; b >= 0; b--)
        c = {c[30:0], 1'b0} ^ ({32{c[31] ^ x[b]}} & POLY);
    end
    return ~c;
  endfunction

  task automatic push_exp(input logic [31:0] d, input logic s, input logic e,
                          input logic a, input string t);
    e_data[ne] = d; e_sop[ne] = s; e_eop[ne] = e; e_app[ne] = a; e_tag[ne] = t;
    ne++;
  endtask

  task automatic add_packet(input int fwd, input int gen, input int td,
                            input int len, input int wob, input int k);
    logic [31:0] w [16];
    string t;
    for (int j = 0; j < len; j++) begin
      if (j == 0) begin
        w[0] = 32'h4A00_0000 ^ (32'(k) * 32'h0101_0007);
        w[0][15] = td[0];
        w[0][14] = k[0];
      end else begin
        w[j] = 32'h9E37_79B9 * 32'(j + 1) + 32'(k * 13);
      end
      b_data[nb] = w[j];
      b_sop[nb]  = (j == 0);
      b_eop[nb]  = (j == len - 1);
      b_fwd[nb]  = fwd[0] ^ ((wob != 0) && (j % 2 == 1));
      b_gen[nb]  = gen[0] ^ ((wob != 0) && (j % 2 == 1));
      nb++;
    end
    if (len == 1) begin
      push_exp(w[0], 1'b1, 1'b1, 1'b0, "R6 one-beat pass");
    end else if (fwd != 0) begin
      t = (wob != 0) ? "R7 forward latched" : "R3 forward";
      for (int j = 0; j < len; j++)
        push_exp(w[j], j == 0, j == len - 1, 1'b0, t);
    end else if (gen != 0) begin
      t = (wob != 0) ? "R7 generate latched" : "R2 generate";
      w[0][15] = 1'b1;
      for (int j = 0; j < len; j++)
        push_exp(w[j], j == 0, 1'b0, 1'b0, t);
      push_exp(ref_crc(w, len), 1'b0, 1'b1, 1'b1, "R4 crc dword");
    end else begin
      t = (wob != 0) ? "R7 clear latched" : "R1 clear";
      w[0][15] = 1'b0;
      for (int j = 0; j < len; j++)
        push_exp(w[j], j == 0, j == len - 1, 1'b0, t);
    end
  endtask

  int  cyc = 0;
  bit  exp_err = 1'b0;
  bit  hung = 1'b0;

  task automatic run_pass(input int pat);
    int bi = 0, ei = 0;
    int guard = 0;
    while ((bi < nb || ei < ne) && !hung) begin
      @(negedge clk);
      cyc++; guard++;
      case (pat)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 1;
        default: out_ready = (cyc % 5) >= 2;
      endcase
      if (bi < nb) begin
        in_valid = 1'b1; in_data = b_data[bi]; in_sop = b_sop[bi]; in_eop = b_eop[bi];
        cfg_fwd_en = b_fwd[bi]; cfg_gen_en = b_gen[bi];
      end else begin
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      end
      #1;
      check(err_unsup == exp_err, "R6 error pulse", 64'(err_unsup), 64'(exp_err));
      if (ei < ne && e_app[ei])
        check(!in_ready, "R5 ready low on appended beat", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        if (ei < ne) begin
          check(out_data == e_data[ei] && out_sop == e_sop[ei] && out_eop == e_eop[ei],
                e_tag[ei], {30'd0, out_sop, out_eop, out_data},
                {30'd0, e_sop[ei], e_eop[ei], e_data[ei]});
          ei++;
        end else begin
          check(1'b0, "R5 extra output beat", 64'(out_data), 64'd0);
        end
      end
      exp_err = in_valid && in_ready && b_sop[bi] && b_eop[bi];
      if (in_valid && in_ready) bi++;
      if (guard > 20000) begin
        hung = 1'b1;
        check(1'b0, "watchdog expired", 64'(bi), 64'(nb));
      end
    end
  endtask

  initial begin
    int k = 0;
    int lens [5] = '{1, 3, 4, 5, 7};
    for (int c = 0; c < 4; c++)
      for (int td = 0; td < 2; td++)
        for (int li = 0; li < 5; li++)
          for (int wob = 0; wob < 2; wob++) begin
            if (!(wob == 1 && lens[li] < 3)) add_packet(c / 2, c % 2, td, lens[li], wob, k);
            k++;
          end
    repeat (3) @(negedge clk);
    #1;
    check(!out_valid && !err_unsup, "R8 reset quiet", {62'd0, out_valid, err_unsup}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!out_valid && !err_unsup, "R8 after reset", {62'd0, out_valid, err_unsup}, 64'd0);
    for (int p = 0; p < 3; p++) if (!hung) run_pass(p);
    @(negedge clk); in_valid = 1'b0; #1;
    check(err_unsup == exp_err, "R6 error pulse", 64'(err_unsup), 64'(exp_err));
    @(negedge clk); #1;
    check(!out_valid && !err_unsup, "R5 idle after drain", {62'd0, out_valid, err_unsup}, 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule